// File: doc/BRIEF.md
# Three-Byte DAC Command Frame Serializer

This block sits on the host side of a serial link to a 16-bit voltage-output converter. A client hands it a two-bit output mode and a sixteen-bit code through a valid/ready handshake. The block turns that request into one 24-bit command word. The word is six zero bits, then the mode, then the code. It sends the word as three back-to-back 8-bit transfers, most significant bit first, and keeps the active-low frame strobe asserted across all three.

The serial clock rests low. Each data bit is presented as the clock rises and held until the clock falls, which is when the receiver samples it. When the last falling edge has passed, the strobe is released and a one-cycle completion pulse is issued. The block then refuses new work until the strobe has stayed high for a programmed number of system clocks. A build option serves byte engines that emit the low bit first: every byte is mirrored before it reaches such an engine, so the wire order is unchanged.

Top module: `dac_frame_tx`

## Requirements
- R1: While reset is held and right after it is released, `sync_n` is high, `sclk` is low, `sdo` is low, `done` is low and `in_ready` is high.
- R2: The 24 bits sampled at the falling edges of `sclk` during one frame are, in arrival order, six zeros, `in_mode[1]`, `in_mode[0]`, then `in_code[15]` down to `in_code[0]` (the word `{6'b0, mode, code}` sent MSB first).
- R3: `sync_n` stays low without a break for the whole frame, exactly 49*HALF_DIV system clocks from the accepting edge, and exactly 24 falling edges of `sclk` occur in that time.
- R4: `sclk` is low whenever `sync_n` is high. Inside a frame, every high phase and every low phase of `sclk`, including the leading and trailing low phases, lasts exactly HALF_DIV system clocks. `sdo` changes only on a rising edge of `sclk`.
- R5: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `sync_n` falls on that edge. `in_ready` is low from acceptance until the gap ends, and each accepted request produces exactly one frame.
- R6: `done` is high for exactly one system clock, the cycle in which `sync_n` returns high.
- R7: Between frames `sync_n` stays high for at least GAP_CYCLES+1 system clocks, and for exactly that many when requests are back to back.
- R8: With LSB_FIRST_ENGINE set, each byte is bit-mirrored before an LSB-first shifter sends it. The wire waveform is identical to the default build.
- R9: With `in_valid` low no frame starts, and changes to `in_mode`/`in_code` after acceptance do not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_mode | input | 2 | Output mode field of the command |
| in_code | input | 16 | Converter code |
| sclk | output | 1 | Serial clock, idle low |
| sync_n | output | 1 | Active-low frame strobe |
| sdo | output | 1 | Serial data, valid at falling `sclk` |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
A wrong byte index or a missed shifter reload shows at once as a wrong bit in the 24-bit word that the bench's receiver model rebuilds. It would also show as a strobe-low length other than 49*HALF_DIV on that same frame. A miscounted phase or gap timer shows as a clock phase or a strobe-high interval of the wrong width, within the frame or gap where it happens. Because both builds of the mirror option are driven with the same requests, a missing mirror shows as a differing word on the first frame with an asymmetric byte.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 3;
  localparam int PAD_W       = 6;
  localparam int MODE_W      = 2;
  localparam int CODE_W      = 16;
  localparam int FRAME_W     = BYTE_W * FRAME_BYTES;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } tx_state_e;

  function automatic logic [BYTE_W-1:0] mirror_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/dac_tick_counter.sv
module dac_tick_counter #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dac_byte_shifter.sv
module dac_byte_shifter #(
  parameter int W         = 8,
  parameter bit LSB_FIRST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         bit_out,
  output logic         last
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q, sh_d, sh_next;
  logic [CW-1:0] cnt_q, cnt_d;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign bit_out = sh_q[0];
      assign sh_next = {1'b0, sh_q[W-1:1]};
    end else begin : g_msb
      assign bit_out = sh_q[W-1];
      assign sh_next = {sh_q[W-2:0], 1'b0};
    end
  endgenerate

  assign last = (cnt_q == CW'(W - 1));

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = din;
      cnt_d = '0;
    end else if (shift) begin
      sh_d  = sh_next;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_frame_pkg::*;
#(
  parameter int HALF_DIV         = 2,
  parameter int GAP_CYCLES       = 4,
  parameter bit LSB_FIRST_ENGINE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [CODE_W-1:0] in_code,
  output logic              sclk,
  output logic              sync_n,
  output logic              sdo,
  output logic              done
);
  localparam int REST_W   = BYTE_W * (FRAME_BYTES - 1);
  localparam int BIDX_W   = $clog2(FRAME_BYTES);
  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(FRAME_BYTES - 1);

  tx_state_e         state_q, state_d;
  logic [REST_W-1:0] rest_q, rest_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic              final_q, final_d;
  logic              sclk_q, sclk_d;
  logic              sync_n_q, sync_n_d;
  logic              sdo_q, sdo_d;
  logic              done_q, done_d;

  logic              half_tick, gap_tick, phase_run, gap_run;
  logic              sh_load, sh_shift, sh_bit, sh_last;
  logic [BYTE_W-1:0] sh_din;
  logic              accept, do_rise;

  logic [BYTE_W-1:0] raw_b  [FRAME_BYTES];
  logic [BYTE_W-1:0] prep_b [FRAME_BYTES];

  always_comb begin
    raw_b[0] = {{PAD_W{1'b0}}, in_mode};
    raw_b[1] = in_code[CODE_W-1:BYTE_W];
    raw_b[2] = in_code[BYTE_W-1:0];
  end

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_lane
    if (LSB_FIRST_ENGINE) begin : g_mirror
      assign prep_b[g] = mirror_byte(raw_b[g]);
    end else begin : g_plain
      assign prep_b[g] = raw_b[g];
    end
  end

  assign phase_run = (state_q == ST_LEAD) || (state_q == ST_SHIFT);
  assign gap_run   = (state_q == ST_GAP);
  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign do_rise   = half_tick &&
                     ((state_q == ST_LEAD) ||
                      ((state_q == ST_SHIFT) && !sclk_q && !final_q));

  dac_tick_counter #(.LIMIT(HALF_DIV)) u_half (
    .clk(clk), .rst_n(rst_n), .en(phase_run), .tick(half_tick)
  );

  dac_tick_counter #(.LIMIT(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .en(gap_run), .tick(gap_tick)
  );

  dac_byte_shifter #(.W(BYTE_W), .LSB_FIRST(LSB_FIRST_ENGINE)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .shift(sh_shift),
    .din(sh_din), .bit_out(sh_bit), .last(sh_last)
  );

  always_comb begin
    state_d  = state_q;
    rest_d   = rest_q;
    bidx_d   = bidx_q;
    final_d  = final_q;
    sclk_d   = sclk_q;
    sync_n_d = sync_n_q;
    sdo_d    = sdo_q;
    done_d   = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_din   = prep_b[0];

    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_LEAD;
          sync_n_d = 1'b0;
          sh_load  = 1'b1;
          sh_din   = prep_b[0];
          rest_d   = {prep_b[1], prep_b[2]};
          bidx_d   = '0;
          final_d  = 1'b0;
        end
      end
      ST_LEAD: begin
        if (half_tick) state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (half_tick) begin
          if (sclk_q) begin
            sclk_d = 1'b0;
          end else if (final_q) begin
            sync_n_d = 1'b1;
            done_d   = 1'b1;
            sdo_d    = 1'b0;
            state_d  = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gap_tick) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (do_rise) begin
      sclk_d = 1'b1;
      sdo_d  = sh_bit;
      if (sh_last) begin
        if (bidx_q == LAST_BYTE) begin
          final_d = 1'b1;
        end else begin
          sh_load = 1'b1;
          sh_din  = rest_q[REST_W-1 -: BYTE_W];
          rest_d  = {rest_q[REST_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
          bidx_d  = bidx_q + 1'b1;
        end
      end else begin
        sh_shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rest_q   <= '0;
      bidx_q   <= '0;
      final_q  <= 1'b0;
      sclk_q   <= 1'b0;
      sync_n_q <= 1'b1;
      sdo_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      rest_q   <= rest_d;
      bidx_q   <= bidx_d;
      final_q  <= final_d;
      sclk_q   <= sclk_d;
      sync_n_q <= sync_n_d;
      sdo_q    <= sdo_d;
      done_q   <= done_d;
    end
  end

  assign sclk   = sclk_q;
  assign sync_n = sync_n_q;
  assign sdo    = sdo_q;
  assign done   = done_q;
endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic sync_n,
  input logic sdo,
  input logic done
);
  p_sclk_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> !sclk);

  p_sdo_stable_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdo));

  p_accept_drops_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !sync_n);

  p_busy_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> !in_ready);

  p_done_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(sync_n));

  p_release_gives_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> done);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_gap_no_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> !in_ready);
endmodule

bind dac_frame_tx dac_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .sclk(sclk), .sync_n(sync_n), .sdo(sdo), .done(done)
);

// File: tb/dac_frame_tx_bench.sv
module dac_frame_rx_model #(
  parameter int HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        sync_n,
  input  logic        sdo,
  input  logic        done,
  input  logic        in_ready,
  output int          frames,
  output logic [23:0] last_word,
  output int          last_bits,
  output int          last_low,
  output int          last_high,
  output int          width_err,
  output int          sdo_err,
  output int          idle_err,
  output int          ready_err,
  output int          done_err
);
  logic        p_sclk, p_sync, p_sdo;
  logic [23:0] word;
  int          bits, low_len, high_len, run;

  always @(negedge clk) begin
    if (!rst_n) begin
      frames = 0; last_word = '0; last_bits = 0; last_low = 0; last_high = 0;
      width_err = 0; sdo_err = 0; idle_err = 0; ready_err = 0; done_err = 0;
      p_sclk = 1'b0; p_sync = 1'b1; p_sdo = 1'b0;
      word = '0; bits = 0; low_len = 0; high_len = 0; run = 0;
    end else begin
      if (!sync_n) begin
        if (p_sync) begin
          last_high = high_len;
          low_len = 1; run = 1; bits = 0; word = '0;
        end else begin
          low_len++;
          if (sclk != p_sclk) begin
            if (run != HALF) width_err++;
            run = 1;
            if (p_sclk && !sclk) begin
              word = {word[22:0], sdo};
              bits++;
            end
          end else begin
            run++;
          end
          if ((sdo != p_sdo) && !(sclk && !p_sclk)) sdo_err++;
        end
        if (in_ready) ready_err++;
      end else begin
        if (!p_sync) begin
          if (run != HALF) width_err++;
          last_word = word; last_bits = bits; last_low = low_len;
          frames++;
          high_len = 1;
        end else begin
          high_len++;
        end
        if (sclk) idle_err++;
      end
      if (done != (sync_n && !p_sync)) done_err++;
      p_sclk = sclk; p_sync = sync_n; p_sdo = sdo;
    end
  end
endmodule

module dac_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int GAP        = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk, rst_n, in_valid;
  logic [1:0]  in_mode;
  logic [15:0] in_code;
  logic        rdy_a, sclk_a, sync_a, sdo_a, done_a;
  logic        rdy_b, sclk_b, sync_b, sdo_b, done_b;

  int checks, fails;

  int          fr_a, bits_a, low_a, high_a, werr_a, serr_a, ierr_a, rerr_a, derr_a;
  int          fr_b, bits_b, low_b, high_b, werr_b, serr_b, ierr_b, rerr_b, derr_b;
  logic [23:0] word_a, word_b;

  dac_frame_tx #(.HALF_DIV(HALF), .GAP_CYCLES(GAP), .LSB_FIRST_ENGINE(1'b0)) u_dac_frame_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .in_mode(in_mode), .in_code(in_code),
    .sclk(sclk_a), .sync_n(sync_a), .sdo(sdo_a), .done(done_a)
  );

  dac_frame_tx #(.HALF_DIV(HALF), .GAP_CYCLES(GAP), .LSB_FIRST_ENGINE(1'b1)) u_dac_frame_tx_lsb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
    .in_mode(in_mode), .in_code(in_code),
    .sclk(sclk_b), .sync_n(sync_b), .sdo(sdo_b), .done(done_b)
  );

  dac_frame_rx_model #(.HALF(HALF)) u_rx_a (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_a), .sync_n(sync_a), .sdo(sdo_a),
    .done(done_a), .in_ready(rdy_a), .frames(fr_a), .last_word(word_a),
    .last_bits(bits_a), .last_low(low_a), .last_high(high_a),
    .width_err(werr_a), .sdo_err(serr_a), .idle_err(ierr_a),
    .ready_err(rerr_a), .done_err(derr_a)
  );

  dac_frame_rx_model #(.HALF(HALF)) u_rx_b (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_b), .sync_n(sync_b), .sdo(sdo_b),
    .done(done_b), .in_ready(rdy_b), .frames(fr_b), .last_word(word_b),
    .last_bits(bits_b), .last_low(low_b), .last_high(high_b),
    .width_err(werr_b), .sdo_err(serr_b), .idle_err(ierr_b),
    .ready_err(rerr_b), .done_err(derr_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int idx, input int mode);
    if (idx < 16)       return 16'(1 << idx);
    else if (idx == 16) return 16'h0000;
    else if (idx == 17) return 16'hFFFF;
    else if (idx == 18) return 16'hA5C3 ^ 16'(mode * 16'h1111);
    else                return 16'h5A3C + 16'(mode);
  endfunction

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_mode = '0; in_code = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sync_a == 1'b1 && sync_b == 1'b1, "R1 sync_n", sync_a, 1);
    check(sclk_a == 1'b0 && sdo_a == 1'b0,  "R1 sclk/sdo", {sclk_a, sdo_a}, 0);
    check(done_a == 1'b0 && rdy_a == 1'b1,  "R1 done/ready", {done_a, rdy_a}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdy_a && rdy_b && sync_a, "R1 after release", {rdy_a, rdy_b, sync_a}, 7);

    // R9 nothing starts without a request
    in_code = 16'h1234; in_mode = 2'b11;
    repeat (40) @(negedge clk);
    check(fr_a == 0 && fr_b == 0 && sync_a, "R9 idle no frame", fr_a + fr_b, 0);

    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 20; k++) begin
        automatic logic [15:0] code = pattern(k, m);
        automatic logic [23:0] exp  = {6'b0, 2'(m), code};
        automatic int n0 = fr_a;
        in_valid = 1'b1;
        in_mode  = 2'(m);
        in_code  = code;
        while (!rdy_a) @(negedge clk);
        @(negedge clk);
        // R9: disturb inputs while the frame is in flight
        in_code = ~code;
        in_mode = ~2'(m);
        do @(posedge clk); while (fr_a == n0 || fr_b == n0);
        check(word_a == exp, "R2 frame word", word_a, exp);
        check(word_b == exp, "R8 mirrored engine word", word_b, exp);
        check(bits_a == 24 && bits_b == 24, "R3 falling edges", bits_a, 24);
        check(low_a == 49*HALF && low_b == 49*HALF, "R3 sync low length", low_a, 49*HALF);
        if (n0 > 0)
          check(high_a == GAP+1 && high_b == GAP+1, "R7 back-to-back gap", high_a, GAP+1);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    repeat (60) @(negedge clk);

    check(fr_a == 80 && fr_b == 80, "R5 one frame per request", fr_a, 80);
    check(werr_a == 0 && werr_b == 0, "R4 sclk phase width", werr_a + werr_b, 0);
    check(serr_a == 0 && serr_b == 0, "R4 sdo changes only at rise", serr_a + serr_b, 0);
    check(ierr_a == 0 && ierr_b == 0, "R4 sclk idle low", ierr_a + ierr_b, 0);
    check(rerr_a == 0 && rerr_b == 0, "R5 ready low while busy", rerr_a + rerr_b, 0);
    check(derr_a == 0 && derr_b == 0, "R6 done pulse", derr_a + derr_b, 0);
    check(sync_a && !sclk_a && rdy_a, "R9 quiet after valid drops", {sync_a, sclk_a, rdy_a}, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule